// File: doc/BRIEF.md
# Chained Debug Trigger Match Unit

This block holds the configuration of ten hardware debug triggers and compares every instruction fetch, load and store against them. The triggers form five fixed pairs, and each pair has a fixed pair of access kinds. A pair can be chained so that it fires only when both members match in the same cycle and ask for the same trap timing. The per-trigger results come out as a four-bit fetch hit vector and a six-bit memory hit vector. A summary flag is the OR of both vectors, and a second flag tells the pipeline whether the trap belongs after the current instruction instead of on it.

Configuration comes in through two valid-qualified write ports. The fetch port addresses the four fetch triggers and the memory port addresses the six load and store triggers. Each write replaces the whole setup of one trigger: enable, match type, operand select, timing, chain and a compare value. All outputs are registered, so a result appears one clock edge after the access that caused it.

Top module: `dbg_trig_match`

## Requirements
- R1: Trigger ids 0 to 9 form the pairs (2p, 2p+1). Ids 0, 1, 6 and 8 watch fetches, ids 2, 3 and 7 watch stores, and ids 4, 5 and 9 watch loads. Fetch slots 0 to 3 of the write port and of `fe_hit` map to ids 0, 1, 6, 8. Memory slots 0 to 5 map to ids 2, 3, 4, 5, 7, 9.
- R2: A write on either configuration port replaces the setup of the addressed trigger at the clock edge where it is valid. An access in that same cycle still sees the old setup. Memory port indices 6 and 7 change nothing.
- R3: Reset, synchronous and active high, disables every trigger and clears all four outputs.
- R4: The match type compares the operand with the stored value: 0 is equal, 2 is operand greater than or equal (unsigned), 3 is operand less than (unsigned), and 1 never matches.
- R5: With select at 0 the operand is the access address. With select at 1 a fetch trigger uses the instruction word (zero-extended) and a store trigger uses the store data. A load trigger with select at 1 never matches.
- R6: A trigger matches only in a cycle where an access of its own kind is valid, and only while its enable is set.
- R7: For a pair whose lower member (id 2p) has its chain bit at 0, each member reports its own match.
- R8: For a chained pair, both members fire when both match and their timing bits are equal. Otherwise neither fires.
- R9: The store/store pair (ids 2 and 3) never fires while it is chained.
- R10: The hit vectors appear on the clock edge after the access. `any_hit` is the OR of all ten bits. `trap_next` is 1 only when at least one trigger fires and every firing trigger has timing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_cfg_valid | input | 1 | Fetch-trigger configuration write |
| fe_cfg_idx | input | 2 | Fetch slot written |
| fe_cfg_en | input | 1 | Trigger enable |
| fe_cfg_mtype | input | 2 | Match type |
| fe_cfg_sel | input | 1 | Operand select (data instead of address) |
| fe_cfg_timing | input | 1 | 0 trap on instruction, 1 trap after it |
| fe_cfg_chain | input | 1 | Chain bit (meaningful on lower pair member) |
| fe_cfg_value | input | VAL_W | Compare value |
| be_cfg_valid | input | 1 | Memory-trigger configuration write |
| be_cfg_idx | input | 3 | Memory slot written |
| be_cfg_en | input | 1 | Trigger enable |
| be_cfg_mtype | input | 2 | Match type |
| be_cfg_sel | input | 1 | Operand select |
| be_cfg_timing | input | 1 | Timing bit |
| be_cfg_chain | input | 1 | Chain bit |
| be_cfg_value | input | VAL_W | Compare value |
| if_valid | input | 1 | Fetch access valid |
| if_pc | input | VAL_W | Fetch address |
| if_insn | input | INSN_W | Fetched instruction word |
| ld_valid | input | 1 | Load access valid |
| ld_addr | input | VAL_W | Load address |
| st_valid | input | 1 | Store access valid |
| st_addr | input | VAL_W | Store address |
| st_data | input | VAL_W | Store data |
| fe_hit | output | 4 | Fetch trigger hits, by fetch slot |
| be_hit | output | 6 | Memory trigger hits, by memory slot |
| any_hit | output | 1 | OR of all hits |
| trap_next | output | 1 | Trap after the instruction instead of on it |

## Verification
The inputs of one cycle are taken at the next rising edge, and every output reflects them from that edge on. A configuration write changes results only for accesses in the cycles after it. The bench drives inputs after the falling edge and computes the expected outputs from its model state as it stood before the edge. It then applies that cycle's writes to the model and compares all outputs one nanosecond after the rising edge. Every cycle is checked this way, so the same-cycle write-versus-access case lands on the old setup.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int unsigned NUM_TRIG = 10;
  localparam int unsigned NUM_PAIR = NUM_TRIG / 2;
  localparam int unsigned NUM_FE   = 4;
  localparam int unsigned NUM_BE   = 6;
  localparam int unsigned FE_IW    = $clog2(NUM_FE);
  localparam int unsigned BE_IW    = $clog2(NUM_BE);

  localparam logic [1:0] MT_EQ = 2'd0;
  localparam logic [1:0] MT_GE = 2'd2;
  localparam logic [1:0] MT_LT = 2'd3;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic       en;
    logic [1:0] mtype;
    logic       sel;
    logic       timing;
    logic       chain;
  } trig_ctl_t;

  function automatic acc_kind_e kind_of(input int unsigned t);
    case (t)
      0, 1, 6, 8: return KIND_FETCH;
      4, 5, 9:    return KIND_LOAD;
      default:    return KIND_STORE;
    endcase
  endfunction

  function automatic int unsigned fe_trig(input int unsigned s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned be_trig(input int unsigned s);
    case (s)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 5;
      4:       return 7;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/dtm_cfg_regs.sv
module dtm_cfg_regs
  import dtm_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fe_wr_valid,
  input  logic [FE_IW-1:0]     fe_wr_idx,
  input  trig_ctl_t            fe_wr_ctl,
  input  logic [VAL_W-1:0]     fe_wr_val,
  input  logic                 be_wr_valid,
  input  logic [BE_IW-1:0]     be_wr_idx,
  input  trig_ctl_t            be_wr_ctl,
  input  logic [VAL_W-1:0]     be_wr_val,
  output trig_ctl_t            ctl_q [NUM_TRIG],
  output logic [VAL_W-1:0]     val_q [NUM_TRIG]
);
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    logic fe_we;
    logic be_we;

    always_comb begin
      fe_we = 1'b0;
      for (int s = 0; s < NUM_FE; s++) begin
        if (fe_trig(s) == t && fe_wr_idx == FE_IW'(s)) fe_we = fe_wr_valid;
      end
    end

    always_comb begin
      be_we = 1'b0;
      for (int s = 0; s < NUM_BE; s++) begin
        if (be_trig(s) == t && be_wr_idx == BE_IW'(s)) be_we = be_wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[t] <= '0;
        val_q[t] <= '0;
      end else if (fe_we) begin
        ctl_q[t] <= fe_wr_ctl;
        val_q[t] <= fe_wr_val;
      end else if (be_we) begin
        ctl_q[t] <= be_wr_ctl;
        val_q[t] <= be_wr_val;
      end
    end
  end
endmodule

// File: rtl/dtm_compare.sv
module dtm_compare
  import dtm_pkg::*;
#(
  parameter int unsigned VAL_W = 64,
  parameter acc_kind_e   KIND  = KIND_FETCH
) (
  input  trig_ctl_t        ctl,
  input  logic [VAL_W-1:0] ref_val,
  input  logic             acc_valid,
  input  logic [VAL_W-1:0] acc_addr,
  input  logic [VAL_W-1:0] acc_data,
  output logic             match
);
  localparam bit DATA_OK = (KIND != KIND_LOAD);

  logic [VAL_W-1:0] operand;
  logic             cmp;
  logic             sel_ok;

  always_comb begin
    operand = ctl.sel ? acc_data : acc_addr;
    sel_ok  = DATA_OK || !ctl.sel;
    case (ctl.mtype)
      MT_EQ:   cmp = (operand == ref_val);
      MT_GE:   cmp = (operand >= ref_val);
      MT_LT:   cmp = (operand <  ref_val);
      default: cmp = 1'b0;
    endcase
    match = ctl.en && acc_valid && sel_ok && cmp;
  end
endmodule

// File: rtl/dtm_pair_resolve.sv
module dtm_pair_resolve #(
  parameter bit FORBID_CHAIN = 1'b0
) (
  input  logic chain,
  input  logic m_lo,
  input  logic m_hi,
  input  logic t_lo,
  input  logic t_hi,
  output logic f_lo,
  output logic f_hi
);
  logic joint;

  always_comb begin
    joint = m_lo && m_hi && (t_lo == t_hi) && !FORBID_CHAIN;
    f_lo  = chain ? joint : m_lo;
    f_hi  = chain ? joint : m_hi;
  end
endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
  import dtm_pkg::*;
#(
  parameter int unsigned VAL_W  = 64,
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fe_cfg_valid,
  input  logic [1:0]        fe_cfg_idx,
  input  logic              fe_cfg_en,
  input  logic [1:0]        fe_cfg_mtype,
  input  logic              fe_cfg_sel,
  input  logic              fe_cfg_timing,
  input  logic              fe_cfg_chain,
  input  logic [VAL_W-1:0]  fe_cfg_value,
  input  logic              be_cfg_valid,
  input  logic [2:0]        be_cfg_idx,
  input  logic              be_cfg_en,
  input  logic [1:0]        be_cfg_mtype,
  input  logic              be_cfg_sel,
  input  logic              be_cfg_timing,
  input  logic              be_cfg_chain,
  input  logic [VAL_W-1:0]  be_cfg_value,
  input  logic              if_valid,
  input  logic [VAL_W-1:0]  if_pc,
  input  logic [INSN_W-1:0] if_insn,
  input  logic              ld_valid,
  input  logic [VAL_W-1:0]  ld_addr,
  input  logic              st_valid,
  input  logic [VAL_W-1:0]  st_addr,
  input  logic [VAL_W-1:0]  st_data,
  output logic [3:0]        fe_hit,
  output logic [5:0]        be_hit,
  output logic              any_hit,
  output logic              trap_next
);
  trig_ctl_t        fe_ctl;
  trig_ctl_t        be_ctl;
  trig_ctl_t        ctl_q [NUM_TRIG];
  logic [VAL_W-1:0] val_q [NUM_TRIG];
  logic [VAL_W-1:0] insn_ext;
  logic [NUM_TRIG-1:0] raw;
  logic [NUM_TRIG-1:0] fired;
  logic [NUM_TRIG-1:0] tim;
  logic [NUM_FE-1:0]   fe_d;
  logic [NUM_BE-1:0]   be_d;

  assign fe_ctl   = '{en: fe_cfg_en, mtype: fe_cfg_mtype, sel: fe_cfg_sel,
                      timing: fe_cfg_timing, chain: fe_cfg_chain};
  assign be_ctl   = '{en: be_cfg_en, mtype: be_cfg_mtype, sel: be_cfg_sel,
                      timing: be_cfg_timing, chain: be_cfg_chain};
  assign insn_ext = VAL_W'(if_insn);

  dtm_cfg_regs #(.VAL_W(VAL_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .fe_wr_valid (fe_cfg_valid),
    .fe_wr_idx   (fe_cfg_idx),
    .fe_wr_ctl   (fe_ctl),
    .fe_wr_val   (fe_cfg_value),
    .be_wr_valid (be_cfg_valid),
    .be_wr_idx   (be_cfg_idx),
    .be_wr_ctl   (be_ctl),
    .be_wr_val   (be_cfg_value),
    .ctl_q       (ctl_q),
    .val_q       (val_q)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_cmp
    localparam acc_kind_e K = kind_of(t);
    assign tim[t] = ctl_q[t].timing;
    if (K == KIND_FETCH) begin : g_fetch
      dtm_compare #(.VAL_W(VAL_W), .KIND(K)) u_cmp (
        .ctl(ctl_q[t]), .ref_val(val_q[t]), .acc_valid(if_valid),
        .acc_addr(if_pc), .acc_data(insn_ext), .match(raw[t]));
    end else if (K == KIND_LOAD) begin : g_load
      dtm_compare #(.VAL_W(VAL_W), .KIND(K)) u_cmp (
        .ctl(ctl_q[t]), .ref_val(val_q[t]), .acc_valid(ld_valid),
        .acc_addr(ld_addr), .acc_data('0), .match(raw[t]));
    end else begin : g_store
      dtm_compare #(.VAL_W(VAL_W), .KIND(K)) u_cmp (
        .ctl(ctl_q[t]), .ref_val(val_q[t]), .acc_valid(st_valid),
        .acc_addr(st_addr), .acc_data(st_data), .match(raw[t]));
    end
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam bit NO_CHAIN = (kind_of(2*p) == KIND_STORE) && (kind_of(2*p+1) == KIND_STORE);
    dtm_pair_resolve #(.FORBID_CHAIN(NO_CHAIN)) u_pair (
      .chain (ctl_q[2*p].chain),
      .m_lo  (raw[2*p]),
      .m_hi  (raw[2*p+1]),
      .t_lo  (tim[2*p]),
      .t_hi  (tim[2*p+1]),
      .f_lo  (fired[2*p]),
      .f_hi  (fired[2*p+1])
    );
  end

  always_comb begin
    for (int s = 0; s < NUM_FE; s++) fe_d[s] = fired[fe_trig(s)];
    for (int s = 0; s < NUM_BE; s++) be_d[s] = fired[be_trig(s)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_hit    <= '0;
      be_hit    <= '0;
      any_hit   <= 1'b0;
      trap_next <= 1'b0;
    end else begin
      fe_hit    <= fe_d;
      be_hit    <= be_d;
      any_hit   <= |fired;
      trap_next <= (|fired) && !(|(fired & ~tim));
    end
  end
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker (
  input logic       clk,
  input logic       rst,
  input logic       fe_cfg_valid,
  input logic [1:0] fe_cfg_idx,
  input logic       fe_cfg_chain,
  input logic       if_valid,
  input logic       ld_valid,
  input logic [3:0] fe_hit,
  input logic [5:0] be_hit,
  input logic       any_hit,
  input logic       trap_next
);
  logic pair0_chained;

  always_ff @(posedge clk) begin
    if (rst) pair0_chained <= 1'b0;
    else if (fe_cfg_valid && fe_cfg_idx == 2'd0) pair0_chained <= fe_cfg_chain;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fe_hit == '0 && be_hit == '0 && !any_hit && !trap_next)); // R3

  AST_SUMMARY_IS_OR: assert property (@(posedge clk) disable iff (rst)
    any_hit == ((|fe_hit) || (|be_hit))); // R10

  AST_TRAP_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    trap_next |-> any_hit); // R10

  AST_FETCH_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !if_valid |=> fe_hit == '0); // R6

  AST_LOAD_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!be_hit[2] && !be_hit[3] && !be_hit[5])); // R6

  AST_CHAIN_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    pair0_chained |=> fe_hit[0] == fe_hit[1]); // R8
endmodule

bind dbg_trig_match dtm_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .fe_cfg_valid (fe_cfg_valid),
  .fe_cfg_idx   (fe_cfg_idx),
  .fe_cfg_chain (fe_cfg_chain),
  .if_valid     (if_valid),
  .ld_valid     (ld_valid),
  .fe_hit       (fe_hit),
  .be_hit       (be_hit),
  .any_hit      (any_hit),
  .trap_next    (trap_next)
);

// File: tb/dbg_trig_match_tb_top.sv
module dbg_trig_match_tb_top;
  localparam int VW = 64;
  localparam int IW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          fe_cfg_valid = 0, fe_cfg_en = 0, fe_cfg_sel = 0, fe_cfg_timing = 0, fe_cfg_chain = 0;
  logic [1:0]    fe_cfg_idx = 0, fe_cfg_mtype = 0;
  logic [VW-1:0] fe_cfg_value = 0;
  logic          be_cfg_valid = 0, be_cfg_en = 0, be_cfg_sel = 0, be_cfg_timing = 0, be_cfg_chain = 0;
  logic [2:0]    be_cfg_idx = 0;
  logic [1:0]    be_cfg_mtype = 0;
  logic [VW-1:0] be_cfg_value = 0;
  logic          if_valid = 0, ld_valid = 0, st_valid = 0;
  logic [VW-1:0] if_pc = 0, ld_addr = 0, st_addr = 0, st_data = 0;
  logic [IW-1:0] if_insn = 0;
  logic [3:0]    fe_hit;
  logic [5:0]    be_hit;
  logic          any_hit, trap_next;

  dbg_trig_match #(.VAL_W(VW), .INSN_W(IW)) dut_i (.*);

  // reference model state, indexed by trigger id
  logic          m_en [10];
  logic [1:0]    m_mt [10];
  logic          m_sel[10], m_tim[10], m_ch[10];
  logic [VW-1:0] m_val[10];

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R3";

  function automatic int fe_id(int s);
    int ids[4] = '{0, 1, 6, 8};
    return ids[s];
  endfunction
  function automatic int be_id(int s);
    int ids[6] = '{2, 3, 4, 5, 7, 9};
    return ids[s];
  endfunction
  // 0 fetch, 1 load, 2 store
  function automatic int kind(int t);
    if (t == 0 || t == 1 || t == 6 || t == 8) return 0;
    if (t == 4 || t == 5 || t == 9) return 1;
    return 2;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step();
    bit raw[10], fire[10];
    logic [3:0] efe; logic [5:0] ebe; logic eany, etn;
    for (int t = 0; t < 10; t++) begin
      logic v; logic [VW-1:0] a, d, op; bit c;
      case (kind(t))
        0: begin v = if_valid; a = if_pc; d = VW'(if_insn); end
        1: begin v = ld_valid; a = ld_addr; d = '0; end
        default: begin v = st_valid; a = st_addr; d = st_data; end
      endcase
      op = m_sel[t] ? d : a;
      case (m_mt[t])
        2'd0: c = (op == m_val[t]);
        2'd2: c = (op >= m_val[t]);
        2'd3: c = (op < m_val[t]);
        default: c = 0;
      endcase
      raw[t] = m_en[t] && v && c && !(kind(t) == 1 && m_sel[t]);
    end
    for (int p = 0; p < 5; p++) begin
      if (m_ch[2*p]) begin
        bit both;
        both = raw[2*p] && raw[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]) && (p != 1);
        fire[2*p] = both; fire[2*p+1] = both;
      end else begin
        fire[2*p] = raw[2*p]; fire[2*p+1] = raw[2*p+1];
      end
    end
    eany = 0; etn = 1;
    for (int t = 0; t < 10; t++) if (fire[t]) begin eany = 1; if (!m_tim[t]) etn = 0; end
    etn = etn && eany;
    for (int s = 0; s < 4; s++) efe[s] = fire[fe_id(s)];
    for (int s = 0; s < 6; s++) ebe[s] = fire[be_id(s)];
    if (fe_cfg_valid) begin
      int t; t = fe_id(fe_cfg_idx);
      m_en[t] = fe_cfg_en; m_mt[t] = fe_cfg_mtype; m_sel[t] = fe_cfg_sel;
      m_tim[t] = fe_cfg_timing; m_ch[t] = fe_cfg_chain; m_val[t] = fe_cfg_value;
    end
    if (be_cfg_valid && be_cfg_idx < 6) begin
      int t; t = be_id(be_cfg_idx);
      m_en[t] = be_cfg_en; m_mt[t] = be_cfg_mtype; m_sel[t] = be_cfg_sel;
      m_tim[t] = be_cfg_timing; m_ch[t] = be_cfg_chain; m_val[t] = be_cfg_value;
    end
    @(posedge clk); #1;
    check("fe_hit", 32'(fe_hit), 32'(efe));
    check("be_hit", 32'(be_hit), 32'(ebe));
    check("any_hit", 32'(any_hit), 32'(eany));
    check("trap_next", 32'(trap_next), 32'(etn));
    @(negedge clk);
    fe_cfg_valid = 0; be_cfg_valid = 0; if_valid = 0; ld_valid = 0; st_valid = 0;
  endtask

  task automatic fwr(int idx, bit en, int mt, bit sel, bit tim, bit ch, logic [VW-1:0] v);
    fe_cfg_valid = 1; fe_cfg_idx = 2'(idx); fe_cfg_en = en; fe_cfg_mtype = 2'(mt);
    fe_cfg_sel = sel; fe_cfg_timing = tim; fe_cfg_chain = ch; fe_cfg_value = v;
  endtask
  task automatic bwr(int idx, bit en, int mt, bit sel, bit tim, bit ch, logic [VW-1:0] v);
    be_cfg_valid = 1; be_cfg_idx = 3'(idx); be_cfg_en = en; be_cfg_mtype = 2'(mt);
    be_cfg_sel = sel; be_cfg_timing = tim; be_cfg_chain = ch; be_cfg_value = v;
  endtask
  task automatic fetch(logic [VW-1:0] pc, logic [IW-1:0] ins);
    if_valid = 1; if_pc = pc; if_insn = ins;
  endtask
  task automatic load(logic [VW-1:0] a);
    ld_valid = 1; ld_addr = a;
  endtask
  task automatic store(logic [VW-1:0] a, logic [VW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < 10; t++) begin
      m_en[t] = 0; m_mt[t] = 0; m_sel[t] = 0; m_tim[t] = 0; m_ch[t] = 0; m_val[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R3: reset state and disabled triggers
    cur_req = "R3";
    check("fe_hit after reset", 32'(fe_hit), 0);
    check("be_hit after reset", 32'(be_hit), 0);
    fetch(0, 0); load(0); store(0, 0); step();

    // R2: write and same-cycle access see old setup, next cycle sees new
    cur_req = "R2";
    fwr(0, 1, 0, 0, 0, 0, 64'h1000); fetch(64'h1000, 0); step();
    fetch(64'h1000, 0); step();
    bwr(6, 1, 2, 0, 0, 0, 64'h0); load(64'h40); store(64'h40, 0); step();
    load(64'h40); store(64'h40, 0); step();

    // R1: slot mapping of both ports
    cur_req = "R1";
    fwr(2, 1, 0, 0, 0, 0, 64'h2000); step();
    fetch(64'h2000, 0); step();
    bwr(4, 1, 0, 0, 0, 0, 64'h3000); step();
    store(64'h3000, 0); step();
    bwr(5, 1, 0, 0, 1, 0, 64'h3100); step();
    load(64'h3100); step();

    // R4: match types
    cur_req = "R4";
    fwr(3, 1, 2, 0, 0, 0, 64'h500); step();
    fetch(64'h4ff, 0); step();
    fetch(64'h500, 0); step();
    fwr(3, 1, 3, 0, 0, 0, 64'h500); step();
    fetch(64'h4ff, 0); step();
    fetch(64'h500, 0); step();
    fwr(3, 1, 1, 0, 0, 0, 64'h500); step();
    fetch(64'h500, 0); step();

    // R5: data select
    cur_req = "R5";
    fwr(1, 1, 0, 1, 0, 0, 64'h13); step();
    fetch(64'h13, 32'h7); step();
    fetch(64'h7, 32'h13); step();
    bwr(1, 1, 0, 1, 0, 0, 64'hbeef); step();
    store(64'h9, 64'hbeef); step();
    bwr(2, 1, 0, 1, 0, 0, 64'h77); step();
    load(64'h77); step();

    // R6: kind gating and enable
    cur_req = "R6";
    fwr(0, 1, 0, 0, 0, 0, 64'h600); step();
    load(64'h600); store(64'h600, 64'h600); step();
    fwr(0, 0, 0, 0, 0, 0, 64'h600); step();
    fetch(64'h600, 0); step();

    // R7 and R8: pair 0 unchained, then chained
    cur_req = "R7";
    fwr(0, 1, 0, 0, 1, 0, 64'h800); fwr(1, 1, 0, 0, 1, 0, 64'h800); step();
    fwr(0, 1, 0, 0, 1, 0, 64'h800); fwr(1, 1, 0, 0, 1, 0, 64'h900); step();
    fetch(64'h800, 0); step();
    cur_req = "R8";
    fwr(0, 1, 0, 0, 1, 1, 64'h800); step();
    fetch(64'h800, 0); step();
    fwr(1, 1, 2, 0, 1, 0, 64'h100); step();
    fetch(64'h800, 0); step();
    fwr(1, 1, 2, 0, 0, 0, 64'h100); step();
    fetch(64'h800, 0); step();

    // R9: store/store pair chained never fires
    cur_req = "R9";
    bwr(0, 1, 0, 0, 0, 1, 64'hA0); step();
    bwr(1, 1, 0, 0, 0, 0, 64'hA0); step();
    store(64'hA0, 0); step();

    // R10: timing summary with mixed timing
    cur_req = "R10";
    bwr(4, 1, 0, 0, 1, 0, 64'hC0); step();
    store(64'hC0, 0); step();
    fwr(2, 1, 0, 0, 0, 0, 64'hC0); step();
    store(64'hC0, 0); fetch(64'hC0, 0); step();

    // random mix across all requirements
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      logic [VW-1:0] pick[4] = '{64'h100, 64'h200, 64'h300, 64'h13};
      if ($urandom_range(0, 2) == 0)
        fwr($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
            1'($urandom), 1'($urandom), pick[$urandom_range(0, 3)]);
      if ($urandom_range(0, 2) == 0)
        bwr($urandom_range(0, 7), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
            1'($urandom), 1'($urandom), pick[$urandom_range(0, 3)]);
      if ($urandom_range(0, 1) == 0) fetch(pick[$urandom_range(0, 3)], IW'(pick[$urandom_range(0, 3)]));
      if ($urandom_range(0, 1) == 0) load(pick[$urandom_range(0, 3)]);
      if ($urandom_range(0, 1) == 0) store(pick[$urandom_range(0, 3)], pick[$urandom_range(0, 3)]);
      step();
    end
    finish_run();
  end
endmodule